// File: doc/BRIEF.md
# Streaming Frame CRC Loader-Checker

This block takes in a configuration bitstream one byte per handshake. The stream is a fixed number of frames. Each frame is a fixed number of data bytes followed by a 16-bit check value. While the data bytes of a frame arrive, the block folds them into a parallel CRC, eight bits per clock. It also holds the bytes in a small frame buffer. When the two check bytes have arrived, it compares them with the computed value.

A frame that passes is committed. Its bytes go to the frame-store write port one per cycle, and its 16 check bits go to a separate check-bit store that has one 16-bit entry per frame, so that a later scrubber can reuse them. A frame that fails halts loading for good. The error output rises, the number of the failing frame is latched, and the input stops accepting bytes. After the last frame has committed, a single-cycle done pulse is raised.

Top module: `frame_crc_loader`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `in_ready` is 1. In that state `error`, `done`, `fs_we` and `cb_we` are 0.
- R2: The check is CRC-16 with polynomial 0x1021, preset 0xFFFF, data fed MSB first and no final inversion. It covers the FW data bytes of a frame. Per frame, the stream order is the FW data bytes, then the CRC high byte, then the CRC low byte.
- R3: A frame that passes is written with `fs_we` high for FW consecutive cycles, starting the cycle after its last CRC byte is accepted. Byte i of frame f goes to address f*FW+i, in increasing i. `in_ready` is 0 during these cycles.
- R4: The check bits of a passing frame are written once, with `cb_we` high, `cb_addr`=f and `cb_data` equal to the CRC. This happens in the first commit cycle of that frame and never before its comparison.
- R5: A frame whose CRC does not match produces no frame-store write and no check-bit write.
- R6: On a mismatch, `error` rises the cycle after the CRC low byte is accepted and stays high until reset. `err_frame` holds the failing frame index and `in_ready` stays 0.
- R7: `done` is high for exactly one cycle, right after the last data byte of frame NF-1 is written. Afterwards `in_ready` stays 0 and `error` stays 0.
- R8: Cycles with `in_valid` low leave the load unchanged, so any pattern of idle gaps gives the same stored contents.
- R9: While `in_ready` is 0 after an error or after done, bytes offered with `in_valid` high cause no write and change neither `error`, `done` nor `err_frame`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| in_data | input | 8 | Stream byte |
| fs_we | output | 1 | Frame-store write enable |
| fs_addr | output | AW | Frame-store byte address |
| fs_data | output | 8 | Frame-store write data |
| cb_we | output | 1 | Check-bit store write enable |
| cb_addr | output | FA | Check-bit store entry (frame index) |
| cb_data | output | 16 | Check bits of the frame |
| done | output | 1 | One-cycle pulse after the last frame commits |
| error | output | 1 | Sticky CRC mismatch flag |
| err_frame | output | FA | Index of the frame that failed |

## Verification
The hardest case to reach from the ports is a mismatch in a middle frame after earlier frames have already committed. That case shows whether a commit and a fault can share or leak state between frames. The stimulus reaches it by sending correct frames up to a chosen index and then corrupting that frame in one of two ways: one bit of its check value flipped, or one data byte changed after its CRC was computed. Random idle gaps on `in_valid` run throughout, and after each halt the bench keeps offering bytes to confirm nothing moves.

// File: rtl/frame_crc_loader.sv
module frame_crc_loader #(
  parameter int          FW   = 4,
  parameter int          NF   = 4,
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       in_valid,
  output logic                                       in_ready,
  input  logic [7:0]                                 in_data,
  output logic                                       fs_we,
  output logic [((NF*FW) > 1 ? $clog2(NF*FW) : 1)-1:0] fs_addr,
  output logic [7:0]                                 fs_data,
  output logic                                       cb_we,
  output logic [(NF > 1 ? $clog2(NF) : 1)-1:0]       cb_addr,
  output logic [15:0]                                cb_data,
  output logic                                       done,
  output logic                                       error,
  output logic [(NF > 1 ? $clog2(NF) : 1)-1:0]       err_frame
);
  localparam int AW = (NF*FW) > 1 ? $clog2(NF*FW) : 1;
  localparam int FA = NF > 1 ? $clog2(NF) : 1;
  localparam int PW = $clog2(FW + 2);

  typedef enum logic [1:0] {LOAD, COMMIT, HALT, FAULT} st_t;
  st_t st;

  logic [7:0]    fbuf [2**PW];
  logic [PW-1:0] pos;
  logic [FA-1:0] frame;
  logic [15:0]   crc;
  logic [7:0]    rx_hi;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = {r[14:0], 1'b0} ^ ((r[15] ^ d[i]) ? POLY : 16'h0000);
    return r;
  endfunction

  wire take = in_valid && in_ready;

  assign in_ready = (st == LOAD);
  assign error    = (st == FAULT);
  assign fs_we    = (st == COMMIT);
  assign fs_addr  = AW'(32'(frame) * FW + 32'(pos));
  assign fs_data  = fbuf[pos];
  assign cb_we    = fs_we && (pos == '0);
  assign cb_addr  = frame;
  assign cb_data  = crc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= LOAD;
      pos       <= '0;
      frame     <= '0;
      crc       <= INIT;
      rx_hi     <= '0;
      done      <= 1'b0;
      err_frame <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        LOAD: if (take) begin
          if (pos < PW'(FW)) begin
            fbuf[pos] <= in_data;
            crc       <= crc_step(crc, in_data);
            pos       <= pos + 1'b1;
          end else if (pos == PW'(FW)) begin
            rx_hi <= in_data;
            pos   <= pos + 1'b1;
          end else begin
            pos <= '0;
            if ({rx_hi, in_data} == crc) st <= COMMIT;
            else begin
              st        <= FAULT;
              err_frame <= frame;
            end
          end
        end
        COMMIT: begin
          if (pos == PW'(FW - 1)) begin
            pos <= '0;
            crc <= INIT;
            if (frame == FA'(NF - 1)) begin
              st   <= HALT;
              done <= 1'b1;
            end else begin
              frame <= frame + 1'b1;
              st    <= LOAD;
            end
          end else pos <= pos + 1'b1;
        end
        default: ;
      endcase
    end
  end

  p_error_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    $past(error) |-> error && !in_ready);
  p_err_frame_hold_r9: assert property (@(posedge clk) disable iff (rst)
    $past(error) |-> $stable(err_frame));
  p_no_write_on_fault_r5: assert property (@(posedge clk) disable iff (rst)
    error |-> !fs_we && !cb_we);
  p_cb_with_fs_r4: assert property (@(posedge clk) disable iff (rst)
    cb_we |-> fs_we);
  p_ready_low_commit_r3: assert property (@(posedge clk) disable iff (rst)
    fs_we |-> !in_ready);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !in_ready);
  p_done_after_write_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(fs_we));
endmodule

// File: tb/sim_frame_crc_loader.sv
`timescale 1ns/1ps
module sim_frame_crc_loader;
  localparam int FW = 4;
  localparam int NF = 4;
  localparam int AW = $clog2(NF*FW);
  localparam int FA = $clog2(NF);

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, fs_we, cb_we, done, error;
  logic [AW-1:0] fs_addr;
  logic [7:0] fs_data;
  logic [FA-1:0] cb_addr, err_frame;
  logic [15:0] cb_data;

  always #2.5 clk = ~clk;

  frame_crc_loader #(.FW(FW), .NF(NF)) u0 (
    .clk, .rst, .in_valid, .in_ready, .in_data, .fs_we, .fs_addr, .fs_data,
    .cb_we, .cb_addr, .cb_data, .done, .error, .err_frame);

  int n_cmp = 0, n_bad = 0;
  int nfs = 0, ncb = 0, ndone = 0;
  int la [64]; int ld [64]; int ca [16]; int cd [16];
  logic [7:0]  fr   [NF][FW];
  logic [15:0] fcrc [NF];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int f);
    logic [15:0] c = 16'hFFFF;
    for (int b = 0; b < FW; b++)
      for (int i = 7; i >= 0; i--) begin
        logic fb = c[15] ^ fr[f][b][i];
        c = c << 1;
        if (fb) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  always @(negedge clk) if (!rst) begin
    if (fs_we) begin la[nfs] = int'(fs_addr); ld[nfs] = int'(fs_data); nfs++; end
    if (cb_we) begin ca[ncb] = int'(cb_addr); cd[ncb] = int'(cb_data); ncb++; end
    if (done) ndone++;
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    nfs = 0; ncb = 0; ndone = 0;
    rst = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input bit gaps);
    if (gaps) while ($urandom % 3 == 0) @(negedge clk);
    in_valid = 1'b1; in_data = b;
    forever begin
      bit r = in_ready;
      @(posedge clk);
      @(negedge clk);
      if (r) break;
    end
    in_valid = 1'b0;
  endtask

  // bad = NF: all good; kind 0: crc bit flipped, kind 1: data byte altered
  task automatic run(input int bad, input int kind, input bit gaps);
    int good;
    do_reset();
    for (int f = 0; f < NF; f++) begin
      for (int b = 0; b < FW; b++) fr[f][b] = 8'($urandom);
      fcrc[f] = ref_crc(f);
    end
    good = (bad < NF) ? bad : NF;
    for (int f = 0; f <= good && f < NF; f++) begin
      logic [15:0] c = fcrc[f];
      int k = int'($urandom % FW);
      if (f == bad && kind == 0) c = c ^ (16'h1 << ($urandom % 16));
      for (int b = 0; b < FW; b++)
        send((f == bad && kind == 1 && b == k) ? fr[f][b] ^ 8'h40 : fr[f][b], gaps);
      send(c[15:8], gaps);
      send(c[7:0], gaps);
    end
    repeat (FW + 4) @(negedge clk);
    chk(nfs == good*FW, "R3/R5 fs write count", nfs, good*FW);
    chk(ncb == good, "R4/R5 cb write count", ncb, good);
    for (int i = 0; i < nfs && i < good*FW; i++) begin
      chk(la[i] == i, "R3 fs address order", la[i], i);
      chk(ld[i] == int'(fr[i/FW][i%FW]), "R3 R8 fs data", ld[i], int'(fr[i/FW][i%FW]));
    end
    for (int j = 0; j < ncb && j < good; j++) begin
      chk(ca[j] == j, "R4 cb address", ca[j], j);
      chk(cd[j] == int'(fcrc[j]), "R2 R4 cb data", cd[j], int'(fcrc[j]));
    end
    chk(ndone == ((bad < NF) ? 0 : 1), "R7 done pulses", ndone, (bad < NF) ? 0 : 1);
    chk(error == (bad < NF), "R6 error flag", int'(error), int'(bad < NF));
    if (bad < NF) chk(int'(err_frame) == bad, "R6 err_frame", int'(err_frame), bad);
    chk(in_ready == 1'b0, "R6/R7 ready low", int'(in_ready), 0);
    // R9: offered bytes ignored after halt
    in_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin in_data = 8'($urandom); @(negedge clk); end
    in_valid = 1'b0;
    @(negedge clk);
    chk(nfs == good*FW && ncb == good, "R9 no writes after halt", nfs, good*FW);
    chk(error == (bad < NF), "R9 error unchanged", int'(error), int'(bad < NF));
    chk(ndone == ((bad < NF) ? 0 : 1), "R9 no extra done", ndone, (bad < NF) ? 0 : 1);
    if (bad < NF) chk(int'(err_frame) == bad, "R9 err_frame held", int'(err_frame), bad);
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
    chk({error, done, fs_we, cb_we} == 4'b0, "R1 outputs in reset", int'({error, done, fs_we, cb_we}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1 && !error && !done, "R1 after reset", int'(in_ready), 1);
    run(NF, 0, 1'b0);
    run(NF, 0, 1'b1);
    run(0, 0, 1'b0);
    run(2, 0, 1'b1);
    run(1, 1, 1'b1);
    run(NF - 1, 1, 1'b0);
    for (int t = 0; t < 6; t++) run(int'($urandom % (NF + 1)), int'($urandom % 2), 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule